// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches 32 already-synchronised GPIO input levels and turns them into interrupt requests. Software configures each pin through a small register file. A pin can be level-sensitive (active high or active low) or edge-sensitive (rising, falling, or either edge). Edge events are held in a per-pin latch until software acknowledges them. Per-pin enable and mask bits then decide which raw conditions reach the masked status and the single combined interrupt line.

Every 32-bit register is split into two 16-bit halves. The lower half, at the base offset, covers pins 0..15. The upper half, at base+4, covers pins 16..31. A write carries a per-bit write-enable mask in wdata[31:16] and the data in wdata[15:0]. Only the bits whose enable is set change, so one pin can be configured without first reading the register back. Reads are combinational and return the selected half in rdata[15:0], with zeros above.

Top module: `gpio_irq_unit`

## Requirements
- R1: Register offsets (byte address, lower half; upper half at +4) are: enable 0x10, mask 0x18, type 0x20, polarity 0x28, both-edge 0x30, masked status 0x50, raw status 0x58, acknowledge 0x60. A write to a half changes only the bits i where wdata[16+i] is 1, setting them to wdata[i]; a read returns that half in rdata[15:0] with rdata[31:16] zero.
- R2: After reset, enable and mask read all ones, type and polarity read zero, no edge event is latched, and irq_out is low.
- R3: With type bit 0 (level), raw status follows the live pin with no latching: it equals the pin when polarity is 1 and the inverted pin when polarity is 0.
- R4: With type 1, polarity 1 and both-edge 0, a 0-to-1 change of the pin sets the latched raw bit at the next clock edge; a 1-to-0 change latches nothing.
- R5: With type 1, polarity 0 and both-edge 0, only a 1-to-0 change latches an event.
- R6: With type 1 and both-edge 1, either change latches an event whatever the polarity bit holds.
- R7: A latched event stays set across any number of cycles, even while the pin is masked, until a 1 is written to its acknowledge bit with the matching write-enable bit set; other acknowledge writes have no effect.
- R8: If an acknowledge and a new edge on the same pin fall in the same cycle, the event remains latched.
- R9: Masked status equals raw status AND enable AND NOT mask.
- R10: irq_out is high exactly when some masked-status bit is 1.
- R11: Acknowledge offsets read back zero, as does any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Synchronised pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte offset of the register half |
| bus_wdata | input | 32 | Write-enable mask [31:16], data [15:0] |
| bus_rdata | output | 32 | Read data of the addressed half |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two functions can act on one pin in the same cycle: software's acknowledge strobe and the detection of a fresh edge. The bench provokes this by driving the pin's new level and the acknowledge write on the same falling clock edge. The following edge then sees both the clear and the set. The check passes only if the raw-status bit still reads 1 afterwards, and a plain acknowledge later clears it. Masked status and irq_out are also checked while enable and mask are toggled around an event that stays latched.

// File: rtl/gpint_pkg.sv
package gpint_pkg;
  localparam int ADDR_W = 7;
  localparam int HALF_W = 16;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_EN   = 7'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK = 7'h18;
  localparam logic [ADDR_W-1:0] OFS_TYPE = 7'h20;
  localparam logic [ADDR_W-1:0] OFS_POL  = 7'h28;
  localparam logic [ADDR_W-1:0] OFS_BOTH = 7'h30;
  localparam logic [ADDR_W-1:0] OFS_MST  = 7'h50;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 7'h58;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 7'h60;

  // byte address of half h of a register
  function automatic logic [ADDR_W-1:0] half_addr(logic [ADDR_W-1:0] base, int h);
    return base + ADDR_W'(h * 4);
  endfunction

  // write-enable merge of a 16-bit half
  function automatic logic [HALF_W-1:0] wm_merge(logic [HALF_W-1:0] old_v,
                                                 logic [DATA_W-1:0] wd);
    return (old_v & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
  endfunction

  function automatic logic edge_hit(logic cur, logic prev, logic pol, logic both);
    if (both) return cur ^ prev;
    if (pol)  return cur & ~prev;
    return ~cur & prev;
  endfunction

  function automatic logic level_hit(logic cur, logic pol);
    return pol ? cur : ~cur;
  endfunction
endpackage

// File: rtl/gpint_cfg.sv
module gpint_cfg
  import gpint_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NPINS-1:0]    en_o,
  output logic [NPINS-1:0]    msk_o,
  output logic [NPINS-1:0]    typ_o,
  output logic [NPINS-1:0]    pol_o,
  output logic [NPINS-1:0]    both_o,
  output logic [NPINS-1:0]    ack_o
);
  localparam int NHALF = NPINS / HALF_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o   <= '1;
      msk_o  <= '1;
      typ_o  <= '0;
      pol_o  <= '0;
      both_o <= '0;
    end else if (wr_en) begin
      for (int h = 0; h < NHALF; h++) begin
        if (addr == half_addr(OFS_EN, h))
          en_o[h*HALF_W +: HALF_W] <= wm_merge(en_o[h*HALF_W +: HALF_W], wdata);
        if (addr == half_addr(OFS_MASK, h))
          msk_o[h*HALF_W +: HALF_W] <= wm_merge(msk_o[h*HALF_W +: HALF_W], wdata);
        if (addr == half_addr(OFS_TYPE, h))
          typ_o[h*HALF_W +: HALF_W] <= wm_merge(typ_o[h*HALF_W +: HALF_W], wdata);
        if (addr == half_addr(OFS_POL, h))
          pol_o[h*HALF_W +: HALF_W] <= wm_merge(pol_o[h*HALF_W +: HALF_W], wdata);
        if (addr == half_addr(OFS_BOTH, h))
          both_o[h*HALF_W +: HALF_W] <= wm_merge(both_o[h*HALF_W +: HALF_W], wdata);
      end
    end
  end

  // acknowledge strobes: write-one, only where the enable bit is set
  always_comb begin
    ack_o = '0;
    for (int h = 0; h < NHALF; h++)
      if (wr_en && addr == half_addr(OFS_ACK, h))
        ack_o[h*HALF_W +: HALF_W] = wdata[15:0] & wdata[31:16];
  end

  // R1: a mask write with no enable bits leaves the mask register alone
  a_r1_mask_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MASK && wdata[31:16] == '0) |=> $stable(msk_o));
endmodule

// File: rtl/gpint_detect.sv
module gpint_detect
  import gpint_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] typ_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] both_i,
  input  logic [NPINS-1:0] ack_i,
  output logic [NPINS-1:0] raw_o
);
  logic [NPINS-1:0] pin_q;
  logic [NPINS-1:0] lat_q;
  logic [NPINS-1:0] lat_d;
  logic [NPINS-1:0] edge_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= '0;
      lat_q <= '0;
    end else begin
      pin_q <= pin_in;
      lat_q <= lat_d;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign edge_evt[i] = edge_hit(pin_in[i], pin_q[i], pol_i[i], both_i[i]);
    // a new edge wins over a simultaneous acknowledge
    assign lat_d[i]    = typ_i[i] & (edge_evt[i] | (lat_q[i] & ~ack_i[i]));
    assign raw_o[i]    = typ_i[i] ? lat_q[i] : level_hit(pin_in[i], pol_i[i]);

    // R7: latched event holds until acknowledged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q[i] && !ack_i[i] && typ_i[i]) |=> lat_q[i]);
    // R7: acknowledge without a new edge clears it
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[i] && !edge_evt[i]) |=> !lat_q[i]);
    // R8: an edge seen in edge mode is latched, acknowledge or not
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (typ_i[i] && edge_evt[i]) |=> lat_q[i]);
    // R6: any change of a both-edge pin is caught
    a_r6_any_change: assert property (@(posedge clk) disable iff (!rst_n)
      (typ_i[i] && both_i[i] && (pin_in[i] != pin_q[i])) |=> lat_q[i]);
    // R3: level pins keep nothing latched
    a_r3_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !typ_i[i] |=> !lat_q[i]);
  end
endmodule

// File: rtl/gpint_rd.sv
module gpint_rd
  import gpint_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  en_i,
  input  logic [NPINS-1:0]  msk_i,
  input  logic [NPINS-1:0]  typ_i,
  input  logic [NPINS-1:0]  pol_i,
  input  logic [NPINS-1:0]  both_i,
  input  logic [NPINS-1:0]  mst_i,
  input  logic [NPINS-1:0]  raw_i,
  output logic [DATA_W-1:0] rdata
);
  localparam int NHALF = NPINS / HALF_W;

  always_comb begin
    rdata = '0;
    for (int h = 0; h < NHALF; h++) begin
      if (addr == half_addr(OFS_EN, h))   rdata[15:0] = en_i[h*HALF_W +: HALF_W];
      if (addr == half_addr(OFS_MASK, h)) rdata[15:0] = msk_i[h*HALF_W +: HALF_W];
      if (addr == half_addr(OFS_TYPE, h)) rdata[15:0] = typ_i[h*HALF_W +: HALF_W];
      if (addr == half_addr(OFS_POL, h))  rdata[15:0] = pol_i[h*HALF_W +: HALF_W];
      if (addr == half_addr(OFS_BOTH, h)) rdata[15:0] = both_i[h*HALF_W +: HALF_W];
      if (addr == half_addr(OFS_MST, h))  rdata[15:0] = mst_i[h*HALF_W +: HALF_W];
      if (addr == half_addr(OFS_RAW, h))  rdata[15:0] = raw_i[h*HALF_W +: HALF_W];
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpint_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPINS-1:0]    pin_in,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_out
);
  logic [NPINS-1:0] cfg_en, cfg_msk, cfg_typ, cfg_pol, cfg_both, ack_stb;
  logic [NPINS-1:0] raw_st, mst;

  gpint_cfg #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .en_o(cfg_en), .msk_o(cfg_msk), .typ_o(cfg_typ), .pol_o(cfg_pol),
    .both_o(cfg_both), .ack_o(ack_stb)
  );

  gpint_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .typ_i(cfg_typ), .pol_i(cfg_pol),
    .both_i(cfg_both), .ack_i(ack_stb), .raw_o(raw_st)
  );

  assign mst     = raw_st & cfg_en & ~cfg_msk;
  assign irq_out = |mst;

  gpint_rd #(.NPINS(NPINS)) u_rd (
    .addr(bus_addr), .en_i(cfg_en), .msk_i(cfg_msk), .typ_i(cfg_typ),
    .pol_i(cfg_pol), .both_i(cfg_both), .mst_i(mst), .raw_i(raw_st),
    .rdata(bus_rdata)
  );

  // R10: the request needs at least one enabled, unmasked pin
  a_r10_needs_open_pin: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> |(cfg_en & ~cfg_msk));
  // R9: a pin with a latched, open event drives the request
  a_r9_open_event_fires: assert property (@(posedge clk) disable iff (!rst_n)
    |(raw_st & cfg_typ & cfg_en & ~cfg_msk) |-> irq_out);
endmodule

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  gpio_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, string what, logic [6:0] a, logic [31:0] exp);
    bus_addr = a;
    #0.5;
    chk(tag, what, bus_rdata, exp);
  endtask

  task automatic set_pin(int p, logic v);
    @(negedge clk);
    pins[p] = v;
  endtask

  task automatic t_reset();
    rd_chk("R2", "enable lo", 7'h10, 32'h0000_FFFF);
    rd_chk("R2", "mask hi", 7'h1C, 32'h0000_FFFF);
    rd_chk("R2", "type lo", 7'h20, 32'h0);
    rd_chk("R2", "polarity hi", 7'h2C, 32'h0);
    rd_chk("R2", "raw lo (active-low level, pins 0)", 7'h58, 32'h0000_FFFF);
    rd_chk("R2", "masked lo", 7'h50, 32'h0);
    chk("R2", "irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_split();
    wr(7'h28, {16'h00F0, 16'h00A0});
    rd_chk("R1", "pol lo partial", 7'h28, 32'h0000_00A0);
    rd_chk("R1", "pol hi untouched", 7'h2C, 32'h0);
    wr(7'h2C, {16'h0003, 16'h0001});
    rd_chk("R1", "pol hi partial", 7'h2C, 32'h0000_0001);
    rd_chk("R1", "pol lo kept", 7'h28, 32'h0000_00A0);
    wr(7'h28, 32'hFFFF_FFFF);
    wr(7'h2C, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    set_pin(3, 1'b1); #0.5;
    rd_chk("R3", "active-high pin3 live", 7'h58, 32'h0000_0008);
    wr(7'h28, {16'h0008, 16'h0000});
    rd_chk("R3", "active-low pin3 high", 7'h58, 32'h0);
    set_pin(3, 1'b0); #0.5;
    rd_chk("R3", "active-low pin3 low", 7'h58, 32'h0000_0008);
    wr(7'h28, {16'h0008, 16'h0008});
    set_pin(3, 1'b1); set_pin(3, 1'b0); #0.5;
    rd_chk("R3", "level pulse not held", 7'h58, 32'h0);
  endtask

  task automatic t_rise();
    wr(7'h24, {16'h0010, 16'h0010});
    set_pin(20, 1'b1); set_pin(20, 1'b0);
    rd_chk("R4", "rise latched pin20", 7'h5C, 32'h0000_0010);
    wr(7'h64, {16'h0010, 16'h0010});
    set_pin(20, 1'b1);
    wr(7'h64, {16'h0010, 16'h0010});
    set_pin(20, 1'b0); @(negedge clk);
    rd_chk("R4", "fall ignored pin20", 7'h5C, 32'h0);
  endtask

  task automatic t_fall();
    wr(7'h20, {16'h0200, 16'h0200});
    wr(7'h28, {16'h0200, 16'h0000});
    set_pin(9, 1'b1); @(negedge clk);
    rd_chk("R5", "rise ignored pin9", 7'h58, 32'h0);
    set_pin(9, 1'b0); @(negedge clk);
    rd_chk("R5", "fall latched pin9", 7'h58, 32'h0000_0200);
    wr(7'h60, {16'h0200, 16'h0200});
  endtask

  task automatic t_both();
    wr(7'h20, {16'h1000, 16'h1000});
    wr(7'h30, {16'h1000, 16'h1000});
    set_pin(12, 1'b1); @(negedge clk);
    rd_chk("R6", "rise pin12", 7'h58, 32'h0000_1000);
    wr(7'h60, {16'h1000, 16'h1000});
    set_pin(12, 1'b0); @(negedge clk);
    rd_chk("R6", "fall pin12", 7'h58, 32'h0000_1000);
    wr(7'h60, {16'h1000, 16'h1000});
    wr(7'h28, {16'h1000, 16'h0000});
    set_pin(12, 1'b1); @(negedge clk);
    rd_chk("R6", "rise pin12 polarity 0", 7'h58, 32'h0000_1000);
    set_pin(12, 1'b0);
    wr(7'h60, {16'h1000, 16'h1000});
  endtask

  task automatic t_ack();
    set_pin(20, 1'b1); set_pin(20, 1'b0);
    wr(7'h64, {16'h0000, 16'h0010});
    rd_chk("R7", "ack without enable bit", 7'h5C, 32'h0000_0010);
    wr(7'h64, {16'h0010, 16'h0000});
    rd_chk("R7", "ack with data 0", 7'h5C, 32'h0000_0010);
    repeat (10) @(negedge clk);
    rd_chk("R7", "held while masked", 7'h5C, 32'h0000_0010);
    wr(7'h64, {16'h0010, 16'h0010});
    rd_chk("R7", "ack clears", 7'h5C, 32'h0);
  endtask

  task automatic t_collide();
    wr(7'h20, {16'h0020, 16'h0020});
    set_pin(5, 1'b1); set_pin(5, 1'b0);
    @(negedge clk);
    pins[5] = 1'b1;
    bus_we = 1'b1; bus_addr = 7'h60; bus_wdata = {16'h0020, 16'h0020};
    @(negedge clk);
    bus_we = 1'b0;
    rd_chk("R8", "edge beats same-cycle ack", 7'h58, 32'h0000_0020);
    set_pin(5, 1'b0);
    wr(7'h60, {16'h0020, 16'h0020});
    rd_chk("R8", "later ack clears", 7'h58, 32'h0);
  endtask

  task automatic t_status();
    set_pin(20, 1'b1); set_pin(20, 1'b0);
    rd_chk("R9", "masked while mask set", 7'h54, 32'h0);
    chk("R10", "irq low while masked", {31'b0, irq_out}, 32'h0);
    wr(7'h1C, {16'h0010, 16'h0000});
    rd_chk("R9", "masked after unmask", 7'h54, 32'h0000_0010);
    chk("R10", "irq high", {31'b0, irq_out}, 32'h1);
    wr(7'h14, {16'h0010, 16'h0000});
    rd_chk("R9", "masked when disabled", 7'h54, 32'h0);
    rd_chk("R9", "raw kept when disabled", 7'h5C, 32'h0000_0010);
    chk("R10", "irq low when disabled", {31'b0, irq_out}, 32'h0);
    wr(7'h14, {16'h0010, 16'h0010});
    chk("R10", "irq back on enable", {31'b0, irq_out}, 32'h1);
    wr(7'h64, {16'h0010, 16'h0010});
    chk("R10", "irq low after ack", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_readback();
    wr(7'h60, 32'hFFFF_FFFF);
    rd_chk("R11", "ack lo reads zero", 7'h60, 32'h0);
    rd_chk("R11", "ack hi reads zero", 7'h64, 32'h0);
    rd_chk("R11", "unmapped 0x00", 7'h00, 32'h0);
    rd_chk("R11", "unmapped 0x7C", 7'h7C, 32'h0);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_ack();
    t_collide();
    t_status();
    t_readback();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule